// File: doc/BRIEF.md
# Write-Once Watchdog Reset Timer

This block is a supervisory watchdog for a small processor subsystem. A narrow divider counts ticks from an external periodic timebase. When software has armed the watchdog and then fails to service it, the divider wraps. The block then raises a one-cycle reset request toward the surrounding reset logic. The timeout is therefore a fixed number of timebase ticks, and its length in time follows the tick rate chosen elsewhere in the chip.

Software reaches the block through one control register. One data bit arms the watchdog and another services it. The arming bit can be written only once after each reset: the first register write, whatever it carries, locks the arming bit until the next reset. Servicing writes are always accepted. The service bit is write-only, and the register read port shows the arming state only.

An expiry acts as a reset of the watchdog itself. In the same edge that raises the request, the arming bit, the lock and the divider all return to their reset values.

Top module: `lockwd_timer`

## Requirements
- R1: Directly after synchronous reset, `rd_data` is all zeros and `rst_req` is 0.
- R2: A first register write with data bit 1 (arm bit) set to 1 arms the watchdog, and `rd_data` bit 1 then reads 1.
- R3: Only the first register write after a reset can change the arm bit. Every later write leaves it unchanged, and this includes a first write carrying arm = 0, which still locks it.
- R4: Data bit 0 (service bit) is write-only. `rd_data` bit 0 and every bit other than bit 1 always read 0.
- R5: While armed, each cycle with `tick` high advances the 2-bit divider. The 4th counted tick drives `rst_req` high on the clock edge that samples it.
- R6: A write with the service bit set zeroes the divider while armed, after the lock is set as well. A full 4 further ticks are then needed for a timeout.
- R7: When a service write and a tick arrive in the same cycle, the service write wins. No timeout occurs even if the divider held its maximum value.
- R8: While not armed, the divider stays at zero and ticks never cause `rst_req`.
- R9: `rst_req` is high for exactly one clock cycle per timeout.
- R10: A timeout clears the arm bit and releases the write lock, so the next write can arm the watchdog again.
- R11: Synchronous reset clears the arm bit and releases the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DATA_W | Write data: bit 1 is arm, bit 0 is service |
| tick | input | 1 | Timebase tick, one cycle per period |
| rd_data | output | DATA_W | Register read value: bit 1 is arm state, all others 0 |
| rst_req | output | 1 | Single-cycle reset request on timeout |

## Verification
The divider is driven with uninterrupted tick runs, with ticks spread out by idle cycles, and with runs broken by service writes at different counts. Together these separate correct counting from off-by-one timeouts and from a divider that does not truly restart. A service write is placed in the same cycle as the tick that would otherwise expire the divider, which shows whether servicing wins over the tick. Tick bursts while disarmed, followed by arming, show whether the divider was held at zero. Sequences of arm and disarm writes, repeated after both a timeout and an external reset, show that the lock takes only the first write and is released again.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;

  // Decoded control register write
  typedef struct packed {
    logic wr;     // write strobe
    logic arm;    // arm bit value
    logic svc;    // service request
  } lockwd_cmd_t;

endpackage

// File: rtl/lockwd_decode.sv
module lockwd_decode
  import lockwd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ARM_BIT = 1,
  parameter int SVC_BIT = 0
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output lockwd_cmd_t       cmd
);

  logic unused_data;
  assign unused_data = ^wr_data;

  always_comb begin
    cmd.wr  = wr_en;
    cmd.arm = wr_en & wr_data[ARM_BIT];
    cmd.svc = wr_en & wr_data[SVC_BIT];
  end

  initial begin
    arm_svc_distinct_chk: assert (ARM_BIT != SVC_BIT);
  end

endmodule

// File: rtl/lockwd_ctrl.sv
module lockwd_ctrl
  import lockwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lockwd_cmd_t cmd,
  input  logic        expire,
  output logic        armed
);

  logic arm_q;
  logic lock_q;

  always_ff @(posedge clk) begin
    if (rst || expire) begin
      arm_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (cmd.wr) begin
      lock_q <= 1'b1;
      if (!lock_q) arm_q <= cmd.arm;
    end
  end

  assign armed = arm_q;

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !expire) |=> (arm_q == $past(arm_q)));

  // R2
  arm_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(arm_q) |-> $past(cmd.wr && !lock_q));

  // R10
  expire_release_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (!arm_q && !lock_q));

endmodule

// File: rtl/lockwd_div.sv
module lockwd_div #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic svc,
  input  logic tick,
  output logic expire
);

  localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

  logic [DIV_W-1:0] cnt_q;

  // Service takes priority over a tick in the same cycle
  assign expire = armed && tick && !svc && (cnt_q == DIV_MAX);

  always_ff @(posedge clk) begin
    if (rst || !armed || svc) cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_q + 1'b1;
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (cnt_q == '0));

  // R6
  svc_zero_chk: assert property (@(posedge clk) disable iff (rst)
    svc |=> (cnt_q == '0));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && tick && !svc && cnt_q != DIV_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lockwd_pulse.sv
module lockwd_pulse (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  output logic req
);

  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= expire;
  end

  assign req = req_q;

endmodule

// File: rtl/lockwd_timer.sv
module lockwd_timer
  import lockwd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 2,
  parameter int ARM_BIT = 1,
  parameter int SVC_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req
);

  lockwd_cmd_t cmd;
  logic        armed;
  logic        expire;

  lockwd_decode #(
    .DATA_W (DATA_W),
    .ARM_BIT(ARM_BIT),
    .SVC_BIT(SVC_BIT)
  ) u_decode (
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .cmd    (cmd)
  );

  lockwd_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .expire(expire),
    .armed (armed)
  );

  lockwd_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .armed (armed),
    .svc   (cmd.svc),
    .tick  (tick),
    .expire(expire)
  );

  lockwd_pulse u_pulse (
    .clk   (clk),
    .rst   (rst),
    .expire(expire),
    .req   (rst_req)
  );

  // Read view: arm state only; the service bit is never stored
  always_comb begin
    rd_data          = '0;
    rd_data[ARM_BIT] = armed;
  end

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R10
  req_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (rd_data[ARM_BIT] == 1'b0));

  // R4
  svc_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[SVC_BIT] == 1'b0);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !rst_req));

endmodule

// File: tb/tb_lockwd_timer.sv
module tb_lockwd_timer;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          tick = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rst_req;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [DW-1:0] ARM = 8'h02;
  localparam logic [DW-1:0] SVC = 8'h01;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockwd_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .rd_data(rd_data), .rst_req(rst_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, results visible at next negedge
  task automatic step(input bit we, input logic [DW-1:0] d, input bit tk);
    wr_en = we; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; tick = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, '0, 0);
    step(0, '0, 0);
    rst = 1'b0;
  endtask

  // n ticks, each followed by gap idle cycles; returns count of req pulses seen
  task automatic ticks(input int n, input int gap, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      step(0, '0, 1);
      if (rst_req) pulses++;
      for (int g = 0; g < gap; g++) begin
        step(0, '0, 0);
        if (rst_req) pulses++;
      end
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    check(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
    check(rst_req == 1'b0, "R1 rst_req", int'(rst_req), 0);
  endtask

  task automatic t_arm_and_timeout();
    int p;
    do_reset();
    step(1, ARM, 0);
    check(rd_data == ARM, "R2 armed readback", int'(rd_data), int'(ARM));
    ticks(3, 0, p);
    check(p == 0, "R5 no req before 4th tick", p, 0);
    step(0, '0, 1);
    check(rst_req == 1'b1, "R5 req on 4th tick", int'(rst_req), 1);
    check(rd_data == '0, "R10 disarmed after timeout", int'(rd_data), 0);
    step(0, '0, 0);
    check(rst_req == 1'b0, "R9 one-cycle pulse", int'(rst_req), 0);
    // lock released: arm again
    step(1, ARM, 0);
    check(rd_data == ARM, "R10 re-arm after timeout", int'(rd_data), int'(ARM));
    ticks(4, 2, p);
    check(p == 1, "R5 spaced ticks timeout once", p, 1);
  endtask

  task automatic t_lock();
    do_reset();
    step(1, ARM, 0);
    step(1, 8'h00, 0);
    check(rd_data == ARM, "R3 disarm write ignored", int'(rd_data), int'(ARM));
    do_reset();
    step(1, 8'h00, 0);
    step(1, ARM, 0);
    check(rd_data == '0, "R3 first write arm=0 locks", int'(rd_data), 0);
    step(1, 8'hFF, 0);
    check(rd_data == '0, "R4 other bits read 0", int'(rd_data), 0);
  endtask

  task automatic t_service();
    int p;
    do_reset();
    step(1, ARM | SVC, 0);
    check(rd_data == ARM, "R4 service bit reads 0", int'(rd_data), int'(ARM));
    ticks(3, 0, p);
    step(1, SVC, 0);
    ticks(3, 1, p);
    check(p == 0, "R6 service restarts divider", p, 0);
    step(0, '0, 1);
    check(rst_req == 1'b1, "R6 timeout 4 ticks after service", int'(rst_req), 1);
  endtask

  task automatic t_collision();
    int p;
    do_reset();
    step(1, ARM, 0);
    ticks(3, 0, p);
    step(1, SVC, 1);
    check(rst_req == 1'b0, "R7 service beats tick", int'(rst_req), 0);
    ticks(3, 0, p);
    check(p == 0, "R7 divider zeroed", p, 0);
    step(0, '0, 1);
    check(rst_req == 1'b1, "R7 timeout after full period", int'(rst_req), 1);
  endtask

  task automatic t_disarmed();
    int p;
    do_reset();
    ticks(10, 0, p);
    check(p == 0, "R8 no req while disarmed", p, 0);
    step(1, ARM, 0);
    ticks(3, 0, p);
    check(p == 0, "R8 divider held at zero", p, 0);
    step(0, '0, 1);
    check(rst_req == 1'b1, "R8 req after 4 armed ticks", int'(rst_req), 1);
  endtask

  task automatic t_ext_reset();
    do_reset();
    step(1, ARM, 0);
    do_reset();
    check(rd_data == '0, "R11 reset disarms", int'(rd_data), 0);
    step(1, ARM, 0);
    check(rd_data == ARM, "R11 reset releases lock", int'(rd_data), int'(ARM));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_arm_and_timeout();
    t_lock();
    t_service();
    t_collision();
    t_disarmed();
    t_ext_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule